// File: doc/BRIEF.md
# Sparsifying Crate-Bus Readout Controller

The block keeps one captured set of converted channel words, each with an overflow flag, and hands them to a crate dataway read cycle. In random mode the cycle's subaddress picks the channel directly. In sequential mode an optional compression pass first discards empty words, and optionally overflow words, and successive reads then walk through the words that survive in ascending channel order.

Each read cycle also drives a response bit (Q). The block raises a service request (LAM) once data can be read. A clear pulse drops the held data state. An initialize pulse does the same and reloads the control register with its default setting: sequential, compressed, with service request.

Top module: `crate_readout_ctrl`

## Requirements
- R1: After reset and after an `init_i` pulse, `csr_o` reads 4'b0111. The bits are bit0 compression enable, bit1 sequential mode, bit2 LAM enable and bit3 overflow suppression. `csr_wr_i` loads `csr_i` into the register.
- R2: In random mode (bit1 = 0), a read cycle (`cyc_i` = 1, `func_i` = 2) returns the captured word of the channel given by `sub_i`.
- R3: In random mode, Q is 1 on every read cycle from the capture of data until a clear. After the clear it is 0.
- R4: In sequential mode, `sub_i` is ignored. Each read returns the lowest-numbered remaining valid word. A high `s2_i` during a read cycle moves to the next word at that clock edge.
- R5: With compression on, words equal to 0 are removed from the sequential list. With compression off, all channels are read in order, zero words included.
- R6: With compression and bit3 both set, words whose overflow flag is 1 are also removed.
- R7: In sequential mode, Q is 1 for every valid word up to and including the last one. Q is 0 on reads after that.
- R8: With compression in sequential mode, LAM rises exactly SCAN_CYCLES clock edges after the edge that samples `data_rdy_i`. Without compression, LAM rises at that sampling edge.
- R9: If compression leaves no valid word, LAM and Q stay 0.
- R10: With bit2 = 0, LAM is held at 0.
- R11: A `clear_i` pulse drops Q and LAM and discards the valid-word list.
- R12: While data is held, a `data_rdy_i` strobe has no effect until a clear. The old words and the LAM state remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ch_data_i | input | N_CH*DATA_W | Channel words, channel 0 in the low bits |
| ch_ovf_i | input | N_CH | Overflow flag for each channel |
| data_rdy_i | input | 1 | Strobe that captures a new set of words |
| csr_wr_i | input | 1 | Control register write strobe |
| csr_i | input | 4 | Control register write value |
| csr_o | output | 4 | Control register contents |
| cyc_i | input | 1 | Dataway cycle active |
| func_i | input | 5 | Function code |
| sub_i | input | $clog2(N_CH) | Subaddress |
| s2_i | input | 1 | Second strobe phase |
| clear_i | input | 1 | Clear function |
| init_i | input | 1 | Initialize command |
| data_o | output | DATA_W | Read data, zero outside read cycles |
| q_o | output | 1 | Response bit for the current cycle |
| lam_o | output | 1 | Service request |

## Verification
The bench builds the block with 16 channels, 8-bit words and a 12-cycle compression pass. The short pass lets it check the exact edge at which LAM appears while a scenario still stays short. All 16 channels remain, so the full-length walk without compression and the drop of Q after the last survivor are covered. The 8-bit words allow distinct nonzero values on every channel.

// File: rtl/crate_readout_pkg.sv
package crate_readout_pkg;
  typedef struct packed {
    logic ovf_sup;
    logic lam_en;
    logic seq_mode;
    logic comp_en;
  } csr_t;

  localparam csr_t CSR_INIT = '{ovf_sup: 1'b0, lam_en: 1'b1, seq_mode: 1'b1, comp_en: 1'b1};
  localparam logic [4:0] FN_READ = 5'd2;
endpackage

// File: rtl/chan_capture.sv
module chan_capture #(
  parameter int N_CH   = 16,
  parameter int DATA_W = 11,
  localparam int IDX_W = $clog2(N_CH)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic [N_CH*DATA_W-1:0]   data_i,
  input  logic [N_CH-1:0]          ovf_i,
  input  logic [IDX_W-1:0]         sel_i,
  output logic [DATA_W-1:0]        word_o,
  output logic [N_CH-1:0]          nz_o,
  output logic [N_CH-1:0]          ovf_o
);
  logic [DATA_W-1:0] word_q [N_CH];
  logic [N_CH-1:0]   ovf_q;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q[g] <= '0;
      else if (load_i) word_q[g] <= data_i[g*DATA_W +: DATA_W];
    end
    assign nz_o[g] = |word_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= '0;
    else if (load_i) ovf_q <= ovf_i;
  end

  assign ovf_o  = ovf_q;
  assign word_o = word_q[sel_i];
endmodule

// File: rtl/sparse_scan.sv
module sparse_scan #(
  parameter int N_CH        = 16,
  parameter int SCAN_CYCLES = 313,
  localparam int CNT_W      = $clog2(SCAN_CYCLES + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            start_i,
  input  logic            comp_i,
  input  logic            ovf_sup_i,
  input  logic [N_CH-1:0] nz_i,
  input  logic [N_CH-1:0] ovf_i,
  output logic            held_o,
  output logic            busy_o,
  output logic            ready_o,
  output logic            ld_o,
  output logic [N_CH-1:0] ld_mask_o
);
  logic             held_q, busy_q, ready_q, ovf_sup_q;
  logic [CNT_W-1:0] cnt_q;
  logic [N_CH-1:0]  keep;
  logic             pass_end;

  for (genvar g = 0; g < N_CH; g++) begin : g_keep
    assign keep[g] = nz_i[g] & ~(ovf_i[g] & ovf_sup_q);
  end

  assign pass_end  = busy_q && (cnt_q == '0);
  assign ld_o      = (start_i && !held_q && !comp_i) || pass_end;
  assign ld_mask_o = busy_q ? keep : '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q    <= 1'b0;
      busy_q    <= 1'b0;
      ready_q   <= 1'b0;
      ovf_sup_q <= 1'b0;
      cnt_q     <= '0;
    end else if (clear_i) begin
      held_q  <= 1'b0;
      busy_q  <= 1'b0;
      ready_q <= 1'b0;
      cnt_q   <= '0;
    end else if (start_i && !held_q) begin
      held_q    <= 1'b1;
      ovf_sup_q <= ovf_sup_i;
      if (comp_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(SCAN_CYCLES - 1);
      end else begin
        ready_q <= 1'b1;
      end
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q  <= 1'b0;
        ready_q <= |keep;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign held_o  = held_q;
  assign busy_o  = busy_q;
  assign ready_o = ready_q;
endmodule

// File: rtl/seq_pointer.sv
module seq_pointer #(
  parameter int N_CH = 16,
  localparam int IDX_W = $clog2(N_CH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             ld_i,
  input  logic [N_CH-1:0]  ld_mask_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  logic [N_CH-1:0] rem_q;

  always_comb begin
    idx_o = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (rem_q[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rem_q <= '0;
    else if (clear_i) rem_q <= '0;
    else if (ld_i) rem_q <= ld_mask_i;
    else if (adv_i && any_o) rem_q[idx_o] <= 1'b0;
  end
endmodule

// File: rtl/crate_readout_ctrl.sv
module crate_readout_ctrl
  import crate_readout_pkg::*;
#(
  parameter int N_CH        = 16,
  parameter int DATA_W      = 11,
  parameter int SCAN_CYCLES = 313,
  localparam int IDX_W      = $clog2(N_CH)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_CH*DATA_W-1:0] ch_data_i,
  input  logic [N_CH-1:0]        ch_ovf_i,
  input  logic                   data_rdy_i,
  input  logic                   csr_wr_i,
  input  logic [3:0]             csr_i,
  output logic [3:0]             csr_o,
  input  logic                   cyc_i,
  input  logic [4:0]             func_i,
  input  logic [IDX_W-1:0]       sub_i,
  input  logic                   s2_i,
  input  logic                   clear_i,
  input  logic                   init_i,
  output logic [DATA_W-1:0]      data_o,
  output logic                   q_o,
  output logic                   lam_o
);
  csr_t             csr_q;
  logic             clr, accept, rd_cyc, adv;
  logic             held, busy, ready, ld, any;
  logic [N_CH-1:0]  ld_mask, nz, ovf;
  logic [IDX_W-1:0] idx, sel;
  logic [DATA_W-1:0] word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) csr_q <= CSR_INIT;
    else if (init_i) csr_q <= CSR_INIT;
    else if (csr_wr_i) csr_q <= csr_t'(csr_i);
  end

  assign clr    = clear_i | init_i;
  assign accept = data_rdy_i & ~held & ~clr;
  assign rd_cyc = cyc_i && (func_i == FN_READ);
  assign adv    = rd_cyc && s2_i && csr_q.seq_mode;
  assign sel    = csr_q.seq_mode ? idx : sub_i;

  chan_capture #(.N_CH(N_CH), .DATA_W(DATA_W)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .data_i (ch_data_i),
    .ovf_i  (ch_ovf_i),
    .sel_i  (sel),
    .word_o (word),
    .nz_o   (nz),
    .ovf_o  (ovf)
  );

  sparse_scan #(.N_CH(N_CH), .SCAN_CYCLES(SCAN_CYCLES)) u_scan (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clr),
    .start_i   (accept),
    .comp_i    (csr_q.comp_en & csr_q.seq_mode),
    .ovf_sup_i (csr_q.ovf_sup),
    .nz_i      (nz),
    .ovf_i     (ovf),
    .held_o    (held),
    .busy_o    (busy),
    .ready_o   (ready),
    .ld_o      (ld),
    .ld_mask_o (ld_mask)
  );

  seq_pointer #(.N_CH(N_CH)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clr),
    .ld_i      (ld),
    .ld_mask_i (ld_mask),
    .adv_i     (adv),
    .idx_o     (idx),
    .any_o     (any)
  );

  assign csr_o  = csr_q;
  assign data_o = rd_cyc ? word : '0;
  assign q_o    = rd_cyc && ready && (csr_q.seq_mode ? any : 1'b1);
  assign lam_o  = csr_q.lam_en && ready;
endmodule

// File: rtl/crate_readout_chk.sv
module crate_readout_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] csr_o,
  input logic       csr_wr_i,
  input logic       cyc_i,
  input logic [4:0] func_i,
  input logic       clear_i,
  input logic       init_i,
  input logic       busy_i,
  input logic       q_o,
  input logic       lam_o
);
  p_lam_gated_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_o[2] |-> !lam_o);

  p_quiet_in_pass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (!lam_o && !q_o));

  p_clear_drops_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!lam_o && !q_o));

  p_lam_kept_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lam_o && !clear_i && !init_i && !csr_wr_i) |=> lam_o);

  p_q_on_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o |-> (cyc_i && func_i == 5'd2));
endmodule

bind crate_readout_ctrl crate_readout_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .csr_o    (csr_o),
  .csr_wr_i (csr_wr_i),
  .cyc_i    (cyc_i),
  .func_i   (func_i),
  .clear_i  (clear_i),
  .init_i   (init_i),
  .busy_i   (busy),
  .q_o      (q_o),
  .lam_o    (lam_o)
);

// File: tb/tb_crate_readout_ctrl.sv
`timescale 1ns/1ps
module tb_crate_readout_ctrl;
  localparam int N = 16;
  localparam int W = 8;
  localparam int S = 12;
  localparam int IW = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [N*W-1:0] ch_data;
  logic [N-1:0]   ch_ovf = '0;
  logic [W-1:0]   dat [N];
  logic           data_rdy = 0, csr_wr = 0, cyc = 0, s2 = 0, clr = 0, ini = 0;
  logic [3:0]     csr_in = '0;
  logic [4:0]     func = '0;
  logic [IW-1:0]  sub = '0;
  logic [3:0]     csr_out;
  logic [W-1:0]   dout;
  logic           q, lam;

  always_comb for (int i = 0; i < N; i++) ch_data[i*W +: W] = dat[i];

  crate_readout_ctrl #(.N_CH(N), .DATA_W(W), .SCAN_CYCLES(S)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ch_data_i(ch_data), .ch_ovf_i(ch_ovf),
    .data_rdy_i(data_rdy), .csr_wr_i(csr_wr), .csr_i(csr_in), .csr_o(csr_out),
    .cyc_i(cyc), .func_i(func), .sub_i(sub), .s2_i(s2), .clear_i(clr),
    .init_i(ini), .data_o(dout), .q_o(q), .lam_o(lam)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    logic [W-1:0] d;
    logic         q;
    bit           cd;
    string        tag;
  } item_t;
  item_t sb[$];
  event  mon_ev;

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always begin
    @(mon_ev);
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check(q == it.q, {it.tag, " q"}, int'(q), int'(it.q));
      if (it.cd) check(dout == it.d, {it.tag, " data"}, int'(dout), int'(it.d));
    end
  end

  task automatic rd(input int s, input logic [W-1:0] d, input logic eq, input bit cd, input string tag);
    item_t it;
    @(negedge clk);
    cyc = 1; func = 5'd2; sub = IW'(s);
    it.d = d; it.q = eq; it.cd = cd; it.tag = tag;
    sb.push_back(it);
    ->mon_ev;
    #2;
    s2 = 1;
    @(negedge clk);
    cyc = 0; s2 = 0; func = '0;
  endtask

  task automatic pulse_load();
    @(negedge clk); data_rdy = 1;
    @(negedge clk); data_rdy = 0;
  endtask

  task automatic pulse_clear();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
  endtask

  task automatic write_csr(input logic [3:0] v);
    @(negedge clk); csr_wr = 1; csr_in = v;
    @(negedge clk); csr_wr = 0;
  endtask

  task automatic drain(input bit comp, input bit osup, input string tag);
    int k = 0;
    for (int i = 0; i < N; i++) begin
      if (!comp || (dat[i] != 0 && !(osup && ch_ovf[i]))) begin
        rd(N - 1 - (k % N), dat[i], 1'b1, 1'b1, tag);
        k++;
      end
    end
    rd(3, '0, 1'b0, 1'b0, {tag, " past last R7"});
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) dat[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(csr_out == 4'b0111, "R1 csr after reset", csr_out, 7);
    check(lam == 0, "R1 lam after reset", lam, 0);
    rd(4, '0, 1'b0, 1'b0, "R1 q before data");

    // R5 R8 compressed sequential, zero words dropped
    for (int i = 0; i < N; i++) dat[i] = (i % 3 == 0) ? '0 : W'(i * 7 + 1);
    pulse_load();
    repeat (S - 1) @(negedge clk);
    check(lam == 0, "R8 lam before pass end", lam, 0);
    @(negedge clk);
    check(lam == 1, "R8 lam at pass end", lam, 1);
    // R12 second strobe ignored while held
    begin
      logic [W-1:0] keep0;
      keep0 = dat[1];
      for (int i = 0; i < N; i++) dat[i] = W'(8'h55);
      pulse_load();
      check(lam == 1, "R12 lam kept", lam, 1);
      rd(9, keep0, 1'b1, 1'b1, "R12 old word R4");
      for (int i = 0; i < N; i++) dat[i] = (i % 3 == 0) ? '0 : W'(i * 7 + 1);
      for (int i = 2; i < N; i++)
        if (i % 3 != 0) rd(i, dat[i], 1'b1, 1'b1, "R4 R5 seq word");
      rd(0, '0, 1'b0, 1'b0, "R7 after last");
    end
    pulse_clear();
    check(lam == 0, "R11 lam after clear", lam, 0);
    rd(2, '0, 1'b0, 1'b0, "R11 q after clear");

    // R6 overflow suppression
    write_csr(4'b1111);
    for (int i = 0; i < N; i++) begin
      dat[i] = W'(i + 1);
      ch_ovf[i] = (i % 4 == 1);
    end
    dat[6] = '0;
    pulse_load();
    repeat (S + 1) @(negedge clk);
    drain(1, 1, "R6 ovf suppressed");
    pulse_clear();

    // R9 nothing survives
    for (int i = 0; i < N; i++) dat[i] = '0;
    ch_ovf = '0;
    pulse_load();
    repeat (S + 3) @(negedge clk);
    check(lam == 0, "R9 lam with empty list", lam, 0);
    rd(0, '0, 1'b0, 1'b0, "R9 q with empty list");
    pulse_clear();

    // R5 R8 sequential, no compression
    write_csr(4'b0110);
    for (int i = 0; i < N; i++) dat[i] = W'(i * 3);
    pulse_load();
    check(lam == 1, "R8 lam at strobe edge", lam, 1);
    drain(0, 0, "R5 uncompressed");
    pulse_clear();

    // R2 R3 random access
    write_csr(4'b0101);
    for (int i = 0; i < N; i++) dat[i] = W'(200 - i);
    pulse_load();
    check(lam == 1, "R3 lam random", lam, 1);
    rd(15, dat[15], 1'b1, 1'b1, "R2 R3 random ch15");
    rd(3, dat[3], 1'b1, 1'b1, "R2 R3 random ch3");
    rd(3, dat[3], 1'b1, 1'b1, "R2 random repeat");
    rd(0, dat[0], 1'b1, 1'b1, "R2 random ch0");
    pulse_clear();
    rd(9, dat[9], 1'b0, 1'b1, "R3 q after clear");

    // R10 LAM disabled
    write_csr(4'b0000);
    pulse_load();
    repeat (2) @(negedge clk);
    check(lam == 0, "R10 lam disabled", lam, 0);
    rd(7, dat[7], 1'b1, 1'b1, "R10 q still given");

    // R1 init
    @(negedge clk); ini = 1;
    @(negedge clk); ini = 0;
    check(csr_out == 4'b0111, "R1 csr after init", csr_out, 7);
    rd(7, '0, 1'b0, 1'b0, "R1 R11 q after init");

    repeat (4) @(negedge clk);
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule